// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache-line misses that are still outstanding for a non-blocking data cache in an in-order pipeline. When a load misses, it is handed over on the miss port. The block then takes one of two actions. If no live entry holds that line, it claims a free entry keyed by the line address. If a live entry already holds the line, it adds the load to that entry as one more waiting target and sends no new memory request. Each target records the word of the line it wants and the destination register. Once accepted, the load leaves the pipeline and its destination register is marked empty in a scoreboard.

Each newly claimed entry places one line request on the memory request port. When the memory side later returns the whole line on the fill port, every waiting target of the matching entry comes out on the write-back lanes in that same cycle. On the next clock edge those registers are marked full and the entry is freed. Decode presents its two source register numbers and gets a hold signal back. The hold is high while either source is still empty, so only an instruction that actually uses a pending value is stalled.

Two ports use valid/ready handshakes. On the miss port a load transfers on a cycle with `miss_valid` and `miss_ready` both high; `miss_ready` does not depend on `miss_valid`. On the memory request port, once `mem_req_valid` is high it stays high and `mem_req_line` stays unchanged until `mem_req_ready` is seen high. The fill port has no back-pressure: every cycle with `fill_valid` high is taken as a completed line.

Top module: `mshr_file`

## Requirements
- R1: A miss accepted with no live entry matching its line claims the lowest-numbered free entry and marks its destination register empty, so `dec_hold` is high for that register from the next cycle.
- R2: A miss accepted whose line matches a live entry joins that entry as another target and causes no additional memory request: each claimed entry yields exactly one accepted request.
- R3: Each word of a line has TGTS (default 2) target slots. A miss to a matching line whose word has no free slot sees `miss_ready` low and is not recorded.
- R4: When all entries are live and the miss matches none of them, `miss_ready` is low. A miss that matches a live entry with a free slot is still accepted when all entries are live. An entry freed by a fill can be claimed from the next cycle.
- R5: `miss_ready` is low while the miss destination register is already marked empty.
- R6: `miss_ready` is low in a cycle where `fill_valid` is high and `fill_line` equals `miss_line`.
- R7: Claimed entries that have not yet been requested are offered on the memory request port lowest entry first, one line per accepted transfer. The offered line is held stable while `mem_req_ready` is low.
- R8: In a cycle with `fill_valid` high and `fill_line` matching a live entry, lane `w*TGTS+t` of the write-back ports is valid exactly when slot t of word w is in use. That lane carries the slot's register on `wb_reg[lane*5 +: 5]` and fill word w (`fill_data[w*32 +: 32]`) on `wb_data[lane*32 +: 32]`. On the next edge those registers become full and the entry becomes free.
- R9: A fill whose line matches no live entry drives no write-back lane valid and leaves every register state unchanged.
- R10: `dec_hold` is high exactly when `dec_src_a` or `dec_src_b` names a register marked empty.
- R11: After reset all entries are free, all registers are full, `mem_req_valid` is low and `miss_ready` is high.
- R12: If a register is marked empty and is written by a fill in the same cycle, it ends up full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Load miss offered |
| miss_ready | output | 1 | Load miss can be accepted this cycle |
| miss_line | input | 16 | Line address of the missing load |
| miss_word | input | 2 | Word within the line |
| miss_dest | input | 5 | Destination register |
| mem_req_valid | output | 1 | Line request offered to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_line | output | 16 | Requested line address |
| fill_valid | input | 1 | Line returned by memory |
| fill_line | input | 16 | Line address of the fill |
| fill_data | input | 128 | All words of the line, word w at bits w*32 |
| wb_valid | output | 8 | Per-lane register write enable |
| wb_reg | output | 40 | Per-lane destination register, 5 bits a lane |
| wb_data | output | 256 | Per-lane write data, 32 bits a lane |
| dec_src_a | input | 5 | First source register at decode |
| dec_src_b | input | 5 | Second source register at decode |
| dec_hold | output | 1 | Decode must stall |

## Verification
A corrupted target list appears at the ports in the very cycle the line returns. Lanes come up valid that should be idle, or a lane carries the wrong register or the wrong word, and the matching `dec_hold` stays high on the next cycle. A wrong entry state or a wrong stored line shows as an extra or missing memory request, a line offered out of order, or a `miss_ready` that refuses a merge or admits a miss beyond capacity. Each of these is visible at most one cycle after the miss or fill that caused it.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_PEND = 2'd1,
    ENT_SENT = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mshr_lowest.sv
module mshr_lowest #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry import mshr_pkg::*; #(
  parameter int LINE_W = 16,
  parameter int WORDS  = 4,
  parameter int TGTS   = 2,
  parameter int REG_W  = 5,
  localparam int SLOTS  = WORDS * TGTS,
  localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int TS_W   = (TGTS > 1) ? $clog2(TGTS) : 1,
  localparam int SI_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_i,
  input  logic                   merge_i,
  input  logic [WOFF_W-1:0]      word_i,
  input  logic [REG_W-1:0]       dest_i,
  input  logic [LINE_W-1:0]      line_i,
  input  logic                   issue_i,
  input  logic                   fill_i,
  output ent_state_e             state_o,
  output logic [LINE_W-1:0]      line_o,
  output logic [SLOTS-1:0]       tgt_v_o,
  output logic [SLOTS*REG_W-1:0] tgt_reg_o,
  output logic                   slot_free_o
);
  ent_state_e          state_q;
  logic [LINE_W-1:0]   line_q;
  logic [SLOTS-1:0]    tgt_v;
  logic [REG_W-1:0]    tgt_reg [SLOTS];
  logic                slot_hit;
  logic [TS_W-1:0]     slot_sel;
  logic [SI_W-1:0]     wr_idx;
  logic [SLOTS-1:0]    wr_onehot;

  // first unused slot of the requested word
  always_comb begin
    slot_hit = 1'b0;
    slot_sel = '0;
    for (int t = TGTS - 1; t >= 0; t--) begin
      if (!tgt_v[int'(word_i) * TGTS + t]) begin
        slot_hit = 1'b1;
        slot_sel = TS_W'(t);
      end
    end
    wr_idx    = SI_W'(int'(word_i) * TGTS + int'(slot_sel));
    wr_onehot = SLOTS'(1) << wr_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENT_FREE;
      line_q  <= '0;
      tgt_v   <= '0;
    end else if (fill_i) begin
      state_q <= ENT_FREE;
      tgt_v   <= '0;
    end else begin
      if (alloc_i) begin
        state_q <= ENT_PEND;
        line_q  <= line_i;
        tgt_v   <= wr_onehot;
      end else if (merge_i) begin
        tgt_v   <= tgt_v | wr_onehot;
      end
      if (issue_i && state_q == ENT_PEND) state_q <= ENT_SENT;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i || merge_i) tgt_reg[wr_idx] <= dest_i;
  end

  assign state_o     = state_q;
  assign line_o      = line_q;
  assign tgt_v_o     = tgt_v;
  assign slot_free_o = slot_hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_flat
    assign tgt_reg_o[s*REG_W +: REG_W] = tgt_reg[s];
  end

  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> state_q == ENT_FREE);
  assert_merge_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> (state_q != ENT_FREE) && slot_hit);
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
  parameter int NREGS = 32,
  localparam int REG_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic [NREGS-1:0] clr_mask,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic [NREGS-1:0] empty_o,
  output logic             hold_o
);
  logic [NREGS-1:0] empty_q;
  logic [NREGS-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_idx] = 1'b1;
  end

  // a fill in the same cycle leaves the register full (R12)
  always_ff @(posedge clk) begin
    if (!rst_n) empty_q <= '0;
    else        empty_q <= (empty_q | set_mask) & ~clr_mask;
  end

  assign empty_o = empty_q;
  assign hold_o  = empty_q[src_a] | empty_q[src_b];

  assert_set_was_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !empty_q[set_idx]);
  assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !clr_mask[set_idx] |=> empty_q[$past(set_idx)]);
endmodule

// File: rtl/mshr_file.sv
module mshr_file import mshr_pkg::*; #(
  parameter int N_ENT  = 4,
  parameter int WORDS  = 4,
  parameter int TGTS   = 2,
  parameter int NREGS  = 32,
  parameter int LINE_W = 16,
  parameter int DATA_W = 32,
  localparam int REG_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SLOTS  = WORDS * TGTS,
  localparam int EI_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  output logic                    miss_ready,
  input  logic [LINE_W-1:0]       miss_line,
  input  logic [WOFF_W-1:0]       miss_word,
  input  logic [REG_W-1:0]        miss_dest,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [LINE_W-1:0]       mem_req_line,
  input  logic                    fill_valid,
  input  logic [LINE_W-1:0]       fill_line,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  output logic [SLOTS-1:0]        wb_valid,
  output logic [SLOTS*REG_W-1:0]  wb_reg,
  output logic [SLOTS*DATA_W-1:0] wb_data,
  input  logic [REG_W-1:0]        dec_src_a,
  input  logic [REG_W-1:0]        dec_src_b,
  output logic                    dec_hold
);
  ent_state_e             ent_state [N_ENT];
  logic [LINE_W-1:0]      ent_line  [N_ENT];
  logic [SLOTS-1:0]       ent_tv    [N_ENT];
  logic [SLOTS*REG_W-1:0] ent_tr    [N_ENT];
  logic [N_ENT-1:0]       ent_room;
  logic [N_ENT-1:0]       busy_vec, free_vec, match_vec, pend_vec, fill_hit;
  logic [N_ENT-1:0]       alloc_e, merge_e, issue_e;
  logic                   any_match, any_free, any_pend;
  logic [EI_W-1:0]        match_idx, free_idx, pend_idx, req_idx;
  logic                   lock_v;
  logic [EI_W-1:0]        lock_idx;
  logic                   accept, fill_clash;
  logic [NREGS-1:0]       reg_empty, clr_mask;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign busy_vec[e]  = ent_state[e] != ENT_FREE;
    assign free_vec[e]  = !busy_vec[e];
    assign pend_vec[e]  = ent_state[e] == ENT_PEND;
    assign match_vec[e] = busy_vec[e] && ent_line[e] == miss_line;
    assign fill_hit[e]  = fill_valid && busy_vec[e] && ent_line[e] == fill_line;
    assign alloc_e[e]   = accept && !any_match && free_idx == EI_W'(e);
    assign merge_e[e]   = accept && any_match && match_idx == EI_W'(e);
    assign issue_e[e]   = mem_req_valid && mem_req_ready && req_idx == EI_W'(e);

    mshr_entry #(.LINE_W(LINE_W), .WORDS(WORDS), .TGTS(TGTS), .REG_W(REG_W)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_e[e]),
      .merge_i     (merge_e[e]),
      .word_i      (miss_word),
      .dest_i      (miss_dest),
      .line_i      (miss_line),
      .issue_i     (issue_e[e]),
      .fill_i      (fill_hit[e]),
      .state_o     (ent_state[e]),
      .line_o      (ent_line[e]),
      .tgt_v_o     (ent_tv[e]),
      .tgt_reg_o   (ent_tr[e]),
      .slot_free_o (ent_room[e])
    );
  end

  mshr_lowest #(.N(N_ENT)) u_pick_match (.req(match_vec), .found(any_match), .idx(match_idx));
  mshr_lowest #(.N(N_ENT)) u_pick_free  (.req(free_vec),  .found(any_free),  .idx(free_idx));
  mshr_lowest #(.N(N_ENT)) u_pick_pend  (.req(pend_vec),  .found(any_pend),  .idx(pend_idx));

  // miss acceptance
  assign fill_clash = fill_valid && fill_line == miss_line;
  assign miss_ready = !fill_clash && !reg_empty[miss_dest] &&
                      (any_match ? ent_room[match_idx] : any_free);
  assign accept     = miss_valid && miss_ready;

  // memory request with a lock so an offered line cannot change
  assign req_idx       = lock_v ? lock_idx : pend_idx;
  assign mem_req_valid = lock_v || any_pend;
  assign mem_req_line  = ent_line[req_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_v   <= 1'b0;
      lock_idx <= '0;
    end else begin
      lock_v   <= mem_req_valid && !mem_req_ready;
      lock_idx <= req_idx;
    end
  end

  // fill write-back lanes
  always_comb begin
    wb_valid = '0;
    wb_reg   = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (fill_hit[e]) begin
        wb_valid = wb_valid | ent_tv[e];
        wb_reg   = wb_reg | ent_tr[e];
      end
    end
  end

  for (genvar l = 0; l < SLOTS; l++) begin : g_lane
    assign wb_data[l*DATA_W +: DATA_W] = fill_data[(l / TGTS)*DATA_W +: DATA_W];
  end

  always_comb begin
    clr_mask = '0;
    for (int l = 0; l < SLOTS; l++) begin
      if (wb_valid[l]) clr_mask[wb_reg[l*REG_W +: REG_W]] = 1'b1;
    end
  end

  mshr_scoreboard #(.NREGS(NREGS)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (accept),
    .set_idx  (miss_dest),
    .clr_mask (clr_mask),
    .src_a    (dec_src_a),
    .src_b    (dec_src_b),
    .empty_o  (reg_empty),
    .hold_o   (dec_hold)
  );

  assert_unique_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_vec) && !any_match |-> !miss_ready);
  assert_fill_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hit));
endmodule

// File: tb/mshr_file_bench.sv
module mshr_file_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         miss_valid;
  logic         miss_ready;
  logic [15:0]  miss_line;
  logic [1:0]   miss_word;
  logic [4:0]   miss_dest;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic [15:0]  mem_req_line;
  logic         fill_valid;
  logic [15:0]  fill_line;
  logic [127:0] fill_data;
  logic [7:0]   wb_valid;
  logic [39:0]  wb_reg;
  logic [255:0] wb_data;
  logic [4:0]   dec_src_a, dec_src_b;
  logic         dec_hold;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mshr_file u_mshr_file (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
    .miss_word(miss_word), .miss_dest(miss_dest),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_hold(dec_hold)
  );

  // {line[15:0], word[1:0], dest[4:0], expected miss_ready}
  localparam logic [23:0] VEC [10] = '{
    {16'h0010, 2'd0, 5'd1, 1'b1},   // R1 claim entry 0
    {16'h0010, 2'd1, 5'd2, 1'b1},   // R2 merge
    {16'h0010, 2'd1, 5'd3, 1'b1},   // R3 second slot of word 1
    {16'h0010, 2'd1, 5'd4, 1'b0},   // R3 word 1 slots used up
    {16'h0020, 2'd2, 5'd5, 1'b1},   // R1 entry 1
    {16'h0030, 2'd3, 5'd6, 1'b1},   // R1 entry 2
    {16'h0040, 2'd0, 5'd7, 1'b1},   // R1 entry 3
    {16'h0050, 2'd0, 5'd8, 1'b0},   // R4 all entries live
    {16'h0020, 2'd0, 5'd1, 1'b0},   // R5 destination pending
    {16'h0020, 2'd0, 5'd9, 1'b1}    // R4 merge while full
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic query(string tag, logic [4:0] a, logic [4:0] b, logic exp);
    dec_src_a = a;
    dec_src_b = b;
    #1;
    chk(tag, 64'(dec_hold), 64'(exp));
  endtask

  task automatic lane(string tag, int l, logic [4:0] r, logic [31:0] d);
    chk(tag, 64'(wb_reg[l*5 +: 5]), 64'(r));
    chk(tag, 64'(wb_data[l*32 +: 32]), 64'(d));
  endtask

  function automatic logic [127:0] line_data(logic [15:0] base);
    logic [127:0] v;
    for (int w = 0; w < 4; w++) v[w*32 +: 32] = {16'h0, base + 16'(w)};
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_line = '0; miss_word = '0; miss_dest = '0;
    mem_req_ready = 1'b0; fill_valid = 1'b0; fill_line = '0; fill_data = '0;
    dec_src_a = '0; dec_src_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 miss_ready", 64'(miss_ready), 64'd1);
    chk("R11 mem_req_valid", 64'(mem_req_valid), 64'd0);
    query("R11 regs full", 5'd1, 5'd31, 1'b0);

    for (int i = 0; i < 10; i++) begin
      miss_line  = VEC[i][23:8];
      miss_word  = VEC[i][7:6];
      miss_dest  = VEC[i][5:1];
      miss_valid = 1'b1;
      #1;
      chk($sformatf("R1-table vector %0d miss_ready", i), 64'(miss_ready), 64'(VEC[i][0]));
      step();
      miss_valid = 1'b0;
    end

    chk("R7 first offered line", 64'(mem_req_line), 64'h10);
    chk("R7 offered valid", 64'(mem_req_valid), 64'd1);
    query("R1 r2 pending", 5'd2, 5'd0, 1'b1);
    query("R10 neither pending", 5'd10, 5'd11, 1'b0);
    query("R10 src_b pending", 5'd12, 5'd9, 1'b1);
    query("R3 refused r4 untouched", 5'd4, 5'd0, 1'b0);
    query("R4 refused r8 untouched", 5'd8, 5'd0, 1'b0);

    mem_req_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R7 request valid", 64'(mem_req_valid), 64'd1);
      chk("R7 request order", 64'(mem_req_line), 64'(16'h10 + 16'(k) * 16'h10));
      step();
    end
    #1;
    chk("R2 no extra requests", 64'(mem_req_valid), 64'd0);

    // fill line 0x10: word0 slot0 r1, word1 slots r2,r3
    fill_valid = 1'b1; fill_line = 16'h0010; fill_data = line_data(16'hA000);
    #1;
    chk("R8 lanes A", 64'(wb_valid), 64'h0D);
    lane("R8 lane0", 0, 5'd1, 32'hA000);
    lane("R8 lane2", 2, 5'd2, 32'hA001);
    lane("R8 lane3", 3, 5'd3, 32'hA001);
    step();
    fill_valid = 1'b0;
    query("R8 r1 r2 full", 5'd1, 5'd2, 1'b0);
    query("R8 r3 full", 5'd3, 5'd0, 1'b0);
    query("R8 r5 still pending", 5'd5, 5'd0, 1'b1);

    miss_line = 16'h0050; miss_word = 2'd0; miss_dest = 5'd8; miss_valid = 1'b1;
    #1;
    chk("R4 freed entry reusable", 64'(miss_ready), 64'd1);
    step();
    miss_valid = 1'b0;
    #1;
    chk("R7 new request valid", 64'(mem_req_valid), 64'd1);
    chk("R7 new request line", 64'(mem_req_line), 64'h50);
    step();
    #1;
    chk("R7 request taken", 64'(mem_req_valid), 64'd0);

    // fill line 0x20 while a miss to it is offered
    fill_valid = 1'b1; fill_line = 16'h0020; fill_data = line_data(16'hB000);
    miss_line = 16'h0020; miss_word = 2'd1; miss_dest = 5'd10; miss_valid = 1'b1;
    #1;
    chk("R6 clash refused", 64'(miss_ready), 64'd0);
    chk("R8 lanes B", 64'(wb_valid), 64'h11);
    lane("R8 lane0 B", 0, 5'd9, 32'hB000);
    lane("R8 lane4 B", 4, 5'd5, 32'hB002);
    step();
    fill_valid = 1'b0;
    miss_valid = 1'b0;
    query("R6 r10 untouched", 5'd10, 5'd0, 1'b0);
    query("R8 r5 r9 full", 5'd5, 5'd9, 1'b0);

    miss_valid = 1'b1;
    #1;
    chk("R1 reclaim after fill", 64'(miss_ready), 64'd1);
    step();
    miss_valid = 1'b0;
    query("R1 r10 pending", 5'd10, 5'd0, 1'b1);

    // fill for a line nobody waits for
    fill_valid = 1'b1; fill_line = 16'h0077; fill_data = line_data(16'hC000);
    #1;
    chk("R9 no lanes", 64'(wb_valid), 64'h00);
    step();
    fill_valid = 1'b0;
    query("R9 r6 still pending", 5'd6, 5'd10, 1'b1);
    query("R9 r6 alone", 5'd6, 5'd0, 1'b1);

    fill_valid = 1'b1; fill_line = 16'h0030; fill_data = line_data(16'hD000);
    #1;
    chk("R8 lanes C", 64'(wb_valid), 64'h40);
    lane("R8 lane6 C", 6, 5'd6, 32'hD003);
    step();
    fill_valid = 1'b0;
    query("R8 r6 full", 5'd6, 5'd0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule